// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address. It reads translation descriptors from memory one word at a time. A walk starts from a context-table pointer and a context number. The first descriptor is fetched from the context table. Each later descriptor is fetched from the table named by the previous one, and the word within that table is chosen by a slice of the virtual address.

Every descriptor fetched is one of three kinds: a pointer to a lower table, a leaf mapping, or invalid. A leaf may appear at any of the four fetch depths, so a single descriptor can map a 4 GiB, 16 MiB, 256 KiB or 4 KiB region. The block reports the leaf word, the depth at which it was found and the composed physical address. A walk that meets an invalid descriptor, or that still holds a table pointer after the fourth fetch, ends with a fault.

The walker handles one translation at a time. It ignores new requests until the current walk has finished.

Top module: `ptw_walker`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `done` and `fault` are all 0.
- R2: If an accepted request has a zero context-table pointer (`ctx_base[31:2]` == 0), `done` and `fault` are 1 in the next cycle and no memory request is made. The reported depth is 0.
- R3: The first fetch address is `{ctx_base[31:2], 6'b0} + 4*ctx_num`.
- R4: The descriptor type is held in bits [1:0]: 1 is a table pointer, 2 is a leaf, and 0 or 3 is invalid. An invalid descriptor ends the walk with `fault`=1, `leaf_pte`=0, `paddr`=0, and `level` set to the depth that was fetched (0 to 3).
- R5: A table pointer at depth d selects the next fetch at `{desc[31:2], 6'b0} + 4*idx`. Here idx is `vaddr[31:24]` for d=0, `vaddr[23:18]` for d=1 and `vaddr[17:12]` for d=2.
- R6: A leaf at depth 0 (the context entry) gives `paddr` = `vaddr` zero-extended to 36 bits, with `level` = 0.
- R7: A leaf at depth d of 1, 2 or 3 gives `paddr` = `{pte[31:8], 12'b0}` ORed with the low 24, 18 or 12 bits of `vaddr` respectively, `level` = d, and `leaf_pte` = the leaf word.
- R8: A table pointer returned by the fourth fetch (depth 3) ends the walk with a fault, `level` = 3, and zero `leaf_pte` and `paddr`.
- R9: `mem_req` stays high with a stable, word-aligned `mem_addr` until `mem_ready` is seen.
- R10: A request raised while `busy` is 1 is ignored, and the walk in progress finishes with its own result.
- R11: `done` is a one-cycle pulse. `fault`, `level`, `leaf_pte` and `paddr` keep their values until the next walk finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only when idle) |
| req_vaddr | input | 32 | Virtual address to translate |
| ctx_base | input | 32 | Context-table pointer, field in bits [31:2] |
| ctx_num | input | 8 | Current context number |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 36 | Byte address of the word read |
| mem_ready | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Descriptor word read |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Walk failed |
| level | output | 2 | Depth at which the walk ended |
| leaf_pte | output | 32 | Leaf descriptor, 0 on fault |
| paddr | output | 36 | Translated physical address, 0 on fault |

## Verification
Directed walks place a leaf at each of the four depths. Each one checks that the offset passed through has the right width. Other directed walks plant codes 0 and 3 and a table pointer at the fourth fetch, to separate the two invalid codes from a run-out of levels. A zero pointer shows whether the block makes any memory access. Random descriptor memories with random contexts, addresses and `mem_ready` stalls mix every path, and they are compared against a bench walk model. Extra requests raised during a walk show whether the block lets the busy walk be overtaken.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 32;
    localparam int PA_W    = 36;
    localparam int DESC_W  = 32;
    localparam int CTX_W   = 8;
    localparam int DEPTHS  = 4;
    localparam int DEPTH_W = $clog2(DEPTHS);
    // pointer fields are shifted so that tables start on 64-byte boundaries
    localparam int PTR_SH  = 6;

    typedef enum logic [1:0] {
        ET_BAD   = 2'd0,
        ET_TABLE = 2'd1,
        ET_LEAF  = 2'd2,
        ET_RSVD  = 2'd3
    } etype_e;

    typedef enum logic {S_IDLE, S_FETCH} wstate_e;

    typedef struct packed {
        logic              fault;
        logic [DEPTH_W-1:0] level;
        logic [DESC_W-1:0] pte;
        logic [PA_W-1:0]   pa;
    } wresult_t;

    // page offset width kept for a leaf at a given depth (depth 0 keeps all)
    function automatic int unsigned offset_bits(input int unsigned depth);
        case (depth)
            0:       return VA_W;
            1:       return 24;
            2:       return 18;
            default: return 12;
        endcase
    endfunction

    function automatic logic [PA_W-1:0] ptr_to_addr(input logic [DESC_W-1:0] d);
        return {{(PA_W-DESC_W-PTR_SH+2){1'b0}}, d[DESC_W-1:2], {PTR_SH{1'b0}}};
    endfunction
endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output logic              is_table,
    output logic              is_leaf
);
    etype_e et;
    always_comb begin
        et       = etype_e'(desc[1:0]);
        is_table = (et == ET_TABLE);
        is_leaf  = (et == ET_LEAF);
    end
endmodule

// File: rtl/ptw_next_addr.sv
module ptw_next_addr
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0]  desc,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [VA_W-1:0]    vaddr,
    output logic [PA_W-1:0]    next_addr
);
    localparam int IDX_W = 8;
    logic [IDX_W-1:0] idx;

    always_comb begin
        case (depth)
            2'd0:    idx = vaddr[31:24];
            2'd1:    idx = {2'b0, vaddr[23:18]};
            default: idx = {2'b0, vaddr[17:12]};
        endcase
        next_addr = ptr_to_addr(desc) + {{(PA_W-IDX_W-2){1'b0}}, idx, 2'b00};
    end
endmodule

// File: rtl/ptw_leaf_pa.sv
module ptw_leaf_pa
    import ptw_pkg::*;
(
    input  logic [DESC_W-1:0]  pte,
    input  logic [DEPTH_W-1:0] depth,
    input  logic [VA_W-1:0]    vaddr,
    output logic [PA_W-1:0]    pa
);
    logic [PA_W-1:0] mask [DEPTHS];
    logic [PA_W-1:0] frame;

    for (genvar g = 0; g < DEPTHS; g++) begin : g_mask
        localparam int unsigned OB = offset_bits(g);
        assign mask[g] = {{(PA_W-OB){1'b0}}, {OB{1'b1}}};
    end

    always_comb begin
        frame = {pte[DESC_W-1:8], 12'b0};
        if (depth == '0)
            pa = {{(PA_W-VA_W){1'b0}}, vaddr};
        else
            pa = frame | ({{(PA_W-VA_W){1'b0}}, vaddr} & mask[depth]);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [DESC_W-1:0]  ctx_base,
    input  logic [CTX_W-1:0]   ctx_num,
    output logic               busy,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_ready,
    input  logic [DESC_W-1:0]  mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [DEPTH_W-1:0] level,
    output logic [DESC_W-1:0]  leaf_pte,
    output logic [PA_W-1:0]    paddr
);
    wstate_e            state;
    logic [DEPTH_W-1:0] depth;
    logic [VA_W-1:0]    va_q;
    wresult_t           res;
    logic               is_table, is_leaf;
    logic [PA_W-1:0]    nxt_addr, leaf_addr, ctx_addr;
    logic               base_zero, accept;

    ptw_classify  u_cls  (.desc(mem_rdata), .is_table(is_table), .is_leaf(is_leaf));
    ptw_next_addr u_nxt  (.desc(mem_rdata), .depth(depth), .vaddr(va_q), .next_addr(nxt_addr));
    ptw_leaf_pa   u_leaf (.pte(mem_rdata), .depth(depth), .vaddr(va_q), .pa(leaf_addr));

    always_comb begin
        base_zero = (ctx_base[DESC_W-1:2] == '0);
        ctx_addr  = ptr_to_addr(ctx_base) + {{(PA_W-CTX_W-2){1'b0}}, ctx_num, 2'b00};
        accept    = req_valid && (state == S_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            depth    <= '0;
            va_q     <= '0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            res      <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    va_q  <= req_vaddr;
                    depth <= '0;
                    if (base_zero) begin
                        done <= 1'b1;
                        res  <= '{fault: 1'b1, level: '0, pte: '0, pa: '0};
                    end else begin
                        state    <= S_FETCH;
                        mem_req  <= 1'b1;
                        mem_addr <= ctx_addr;
                    end
                end
                S_FETCH: if (mem_ready) begin
                    if (is_leaf) begin
                        done    <= 1'b1;
                        res     <= '{fault: 1'b0, level: depth, pte: mem_rdata, pa: leaf_addr};
                        state   <= S_IDLE;
                        mem_req <= 1'b0;
                    end else if (is_table && depth != DEPTH_W'(DEPTHS-1)) begin
                        depth    <= depth + 1'b1;
                        mem_addr <= nxt_addr;
                    end else begin
                        done    <= 1'b1;
                        res     <= '{fault: 1'b1, level: depth, pte: '0, pa: '0};
                        state   <= S_IDLE;
                        mem_req <= 1'b0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign fault    = res.fault;
    assign level    = res.level;
    assign leaf_pte = res.pte;
    assign paddr    = res.pa;

    assert_word_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_addr[1:0] == 2'b00);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_fault_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (leaf_pte == '0 && paddr == '0));
    assert_zero_base_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && ctx_base[DESC_W-1:2] == '0) |=> (done && fault && !mem_req));
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(va_q));
    assert_ctx_leaf_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && level == '0) |-> paddr == {{(PA_W-VA_W){1'b0}}, va_q});
    assert_hold_result_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(paddr) && $stable(fault));
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] ctx_base = '0;
    logic [7:0]  ctx_num = '0;
    logic        busy, mem_req, mem_ready, done, fault;
    logic [35:0] mem_addr, paddr;
    logic [31:0] mem_rdata, leaf_pte;
    logic [1:0]  level;

    logic [31:0] mem [0:4095];
    int n_chk = 0, n_fail = 0, hs_cnt = 0, cyc = 0;
    bit  stall_on = 1'b1;

    always #10 clk = ~clk;

    assign mem_rdata = (mem_addr < 36'h4000) ? mem[mem_addr[13:2]] : 32'h0;

    ptw_walker u_dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .ctx_base(ctx_base), .ctx_num(ctx_num), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done),
        .fault(fault), .level(level), .leaf_pte(leaf_pte), .paddr(paddr));

    initial mem_ready = 1'b1;
    always @(negedge clk) mem_ready = stall_on ? (($urandom % 4) != 0) : 1'b1;
    always @(posedge clk) begin
        if (mem_req && mem_ready) hs_cnt <= hs_cnt + 1;
        cyc <= cyc + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
        summary();
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [35:0] a);
        return (a < 36'h4000) ? mem[a[13:2]] : 32'h0;
    endfunction

    task automatic ref_walk(input logic [31:0] va, input logic [31:0] base, input logic [7:0] cx,
                            output bit f, output logic [1:0] lv, output logic [31:0] pte,
                            output logic [35:0] pa);
        logic [35:0] a;
        logic [31:0] w;
        logic [7:0]  idx;
        int sh;
        f = 1'b1; lv = 2'd0; pte = '0; pa = '0;
        if (base[31:2] == 0) return;
        a = {4'b0, base[31:2], 2'b0} * 36'd16 + {26'b0, cx, 2'b0};
        for (int d = 0; d < 4; d++) begin
            w = rd(a);
            lv = 2'(d);
            if (w[1:0] == 2'd2) begin
                f = 1'b0; pte = w;
                if (d == 0) pa = {4'b0, va};
                else begin
                    sh = (d == 1) ? 24 : (d == 2) ? 18 : 12;
                    pa = ({4'b0, w} >> 8 << 12) | ({4'b0, va} & ((36'h1 << sh) - 1));
                end
                return;
            end
            if (w[1:0] != 2'd1 || d == 3) return;
            idx = (d == 0) ? va[31:24] : (d == 1) ? {2'b0, va[23:18]} : {2'b0, va[17:12]};
            a = {4'b0, w[31:2], 2'b0} * 36'd16 + {26'b0, idx, 2'b0};
        end
    endtask

    // one walk: start, optional late requests while busy, compare on done
    task automatic run_walk(input logic [31:0] va, input logic [31:0] base, input logic [7:0] cx,
                            input bit poke_busy, input string tag);
        bit f; logic [1:0] lv; logic [31:0] pte; logic [35:0] pa;
        int hs0, waited;
        ref_walk(va, base, cx, f, lv, pte, pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; ctx_base = base; ctx_num = cx;
        hs0 = hs_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        if (base[31:2] == 0) begin
            check(done && fault && !mem_req, "R2 zero base ends next cycle", {done, fault, mem_req}, 3'b110);
        end else if (busy) begin
            check(mem_addr == ({4'b0, base[31:2], 2'b0} * 36'd16 + {26'b0, cx, 2'b0}),
                  "R3 first fetch address", mem_addr,
                  {4'b0, base[31:2], 2'b0} * 36'd16 + {26'b0, cx, 2'b0});
        end
        waited = 0;
        while (!done && waited < 200) begin
            if (poke_busy && busy) begin
                req_valid = 1'b1; req_vaddr = ~va; ctx_base = base ^ 32'h40; ctx_num = cx + 8'd1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            waited++;
        end
        req_valid = 1'b0;
        check(done, {tag, " done seen"}, done, 1);
        check(fault == f && level == lv && leaf_pte == pte && paddr == pa, tag,
              {fault, level, paddr}, {f, lv, pa});
        if (base[31:2] == 0) check(hs_cnt == hs0, "R2 no memory access", hs_cnt - hs0, 0);
        @(negedge clk);
        check(!done && paddr == pa && fault == f, "R11 pulse and hold", {done, fault}, {1'b0, f});
        if (poke_busy) check(!busy, "R10 late request not started", busy, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy && !mem_req && !done && !fault, "R1 reset state", {busy, mem_req, done, fault}, 0);
        rst = 1'b0;

        // directed: base ptr 1 -> ctx table at 0x40, ctx 2 -> word at 0x48
        run_walk(32'h1234_5678, 32'h0000_0003, 8'd2, 1'b0, "R2 zero pointer");
        mem[18] = 32'hABCD_E002;
        run_walk(32'hDEAD_BEEF, 32'h0000_0004, 8'd2, 1'b0, "R6 leaf at context entry");
        mem[18] = (32'd4 << 2) | 32'd1;                 // table at 0x100
        mem[(256 + 4*8'h12) / 4] = 32'h1234_5602;       // depth-1 leaf
        run_walk(32'h12AB_CDEF, 32'h0000_0004, 8'd2, 1'b0, "R7 leaf depth 1 (24-bit offset)");
        mem[(256 + 4*8'h12) / 4] = (32'd8 << 2) | 32'd1; // table at 0x200
        mem[(512 + 4*6'h2A) / 4] = 32'hFEDC_BA02;
        run_walk(32'h12A8_0123, 32'h0000_0004, 8'd2, 1'b1, "R7 R10 leaf depth 2 (18-bit offset)");
        mem[(512 + 4*6'h2A) / 4] = (32'd16 << 2) | 32'd1; // table at 0x400
        mem[(1024 + 4*6'h15) / 4] = 32'h8765_4302;
        run_walk(32'h12A9_5ABC, 32'h0000_0004, 8'd2, 1'b0, "R5 R7 leaf depth 3 (12-bit offset)");
        mem[(1024 + 4*6'h15) / 4] = (32'd20 << 2) | 32'd1;
        run_walk(32'h12A9_5ABC, 32'h0000_0004, 8'd2, 1'b0, "R8 pointer at fourth fetch");
        mem[(1024 + 4*6'h15) / 4] = 32'h5555_5553;
        run_walk(32'h12A9_5ABC, 32'h0000_0004, 8'd2, 1'b0, "R4 code 3 invalid at depth 3");
        mem[(512 + 4*6'h2A) / 4] = 32'h7777_7700;
        run_walk(32'h12A8_0123, 32'h0000_0004, 8'd2, 1'b1, "R4 code 0 invalid at depth 2");

        // random memories, contexts and addresses
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 4096; i++) begin
                int t = $urandom % 8;
                logic [31:0] hi = $urandom;
                if (t < 3) mem[i] = (($urandom % 256) << 2) | 32'd1;
                else if (t < 6) mem[i] = {hi[31:2], 2'd2};
                else if (t == 6) mem[i] = {hi[31:2], 2'd0};
                else mem[i] = {hi[31:2], 2'd3};
            end
            for (int k = 0; k < 40; k++) begin
                logic [31:0] b = ((($urandom % 16) == 0) ? 32'd0 : (($urandom % 256) << 2)) | ($urandom % 4);
                run_walk($urandom, b, 8'($urandom), ($urandom % 3) == 0, "R4 R5 R7 random walk");
            end
        end
        summary();
    end
endmodule